// File: doc/BRIEF.md
# Transmit FIFO Host Write Port with Frame Status Store

This block sits between a host and a byte-wide transmit FIFO. The host writes one byte per strobe and marks the final byte of each frame. Every byte that is accepted is acknowledged by a one-cycle pulse. A write made while the FIFO has no room is neither acknowledged nor stored, so the host has to present that byte again later. A data-request output stays high while the free space is at or above a programmable watermark. When the request falls, the host may keep writing, based on its own count of the space that remains. The watermark is captured only when the transmit path is reset.

The MAC side pops bytes in order and reports each completed frame with a status word. The block holds up to two unread status words. The host reads the oldest one through a read strobe. While two words are pending, the start permit for the next frame stays low, however many whole frames are waiting in the FIFO.

Top module: `tx_host_port`

## Requirements
- R1: While in reset and in the first cycle after it, `wr_ack`=0, `frame_cnt`=0, `mac_avail`=0, `start_ok`=0 and `st_data`=0.
- R2: `data_req` is 1 exactly when the free byte count (DEPTH minus the bytes held) is greater than or equal to the captured watermark.
- R3: A write with `wr_en`=1 while fewer than DEPTH bytes are held is stored, and `wr_ack` is high for one cycle in the following cycle. With no write, `wr_ack` is 0.
- R4: A write while DEPTH bytes are held produces no `wr_ack` and its data is never stored. This applies even when `mac_rd` pops a byte in the same cycle.
- R5: `mac_data` presents the bytes in the order they were accepted. `mac_last` marks a byte written with `wr_last`=1. `mac_avail` is 1 while any byte is held.
- R6: `frame_cnt` counts the whole frames held. It goes up on an accepted write with `wr_last`=1 and down when a byte marked last is popped.
- R7: Up to two status words are kept. `st_data` = {1'b1 valid, underflow, retry[RW-1:0]} for the oldest word, `st_rd` pops that word, and `st_data` is all zeros when no word is pending.
- R8: `start_ok` is 1 exactly when `frame_cnt` > 0 and fewer than two status words are pending.
- R9: A `done_valid` arriving while two words are pending is dropped, unless `st_rd` pops a word in the same cycle. In that case both the pop and the push take effect.
- R10: The watermark is loaded from `wm_cfg` only during reset or a `path_reset` cycle. `path_reset` empties the FIFO and clears `frame_cnt`, but keeps the status words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| path_reset | input | 1 | Empties the FIFO and captures the watermark |
| wm_cfg | input | AW+1 | Free-space watermark in bytes |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DW | Host write byte |
| wr_last | input | 1 | Marks the final byte of a frame |
| wr_ack | output | 1 | Acknowledge pulse for an accepted write |
| data_req | output | 1 | Requests more data from the host |
| mac_rd | input | 1 | MAC pops the head byte |
| mac_data | output | DW | Head byte |
| mac_last | output | 1 | Head byte ends a frame |
| mac_avail | output | 1 | FIFO holds at least one byte |
| frame_cnt | output | AW+1 | Whole frames held |
| start_ok | output | 1 | MAC may begin a new frame |
| done_valid | input | 1 | Frame completed, status present |
| done_uflo | input | 1 | Underflow flag of completed frame |
| done_retry | input | RW | Retry/error field of completed frame |
| st_rd | input | 1 | Host status read strobe, pops oldest |
| st_data | output | RW+2 | Oldest status word or zero |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a host write and a MAC pop while the FIFO is full. The bench drives both in one cycle, then drains the FIFO and checks that the refused byte never shows up and that the FIFO reports empty after exactly the expected number of pops. The second pair is a status push and a status read while both status slots are full. The bench reads the entries back in order and expects the new word to follow the remaining old one. A push with no read at that point is expected to vanish, which the bench confirms by reading back zeros.

// File: rtl/tx_host_port.sv
module tx_host_port #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          path_reset,
  input  logic [$clog2(DEPTH):0] wm_cfg,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  output logic          wr_ack,
  output logic          data_req,
  input  logic          mac_rd,
  output logic [DW-1:0] mac_data,
  output logic          mac_last,
  output logic          mac_avail,
  output logic [$clog2(DEPTH):0] frame_cnt,
  output logic          start_ok,
  input  logic          done_valid,
  input  logic          done_uflo,
  input  logic [RW-1:0] done_retry,
  input  logic          st_rd,
  output logic [RW+1:0] st_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, wm_q;
  logic [RW:0]   st0, st1;
  logic [1:0]    st_cnt;

  wire full   = (count == CW'(DEPTH));
  wire wr_ok  = wr_en && !full && !path_reset;
  wire rd_ok  = mac_rd && (count != '0) && !path_reset;
  wire head_last = mem[rd_ptr][DW];
  wire push_ok = done_valid && (st_cnt != 2'd2 || st_rd);
  wire pop_ok  = st_rd && (st_cnt != 2'd0);
  wire [RW:0] st_new = {done_uflo, done_retry};

  assign data_req  = (CW'(DEPTH) - count) >= wm_q;
  assign mac_data  = mem[rd_ptr][DW-1:0];
  assign mac_last  = head_last;
  assign mac_avail = (count != '0);
  assign start_ok  = (frame_cnt != '0) && (st_cnt != 2'd2);
  assign st_data   = (st_cnt != 2'd0) ? {1'b1, st0} : '0;

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_ptr] <= {wr_last, wr_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; frame_cnt <= '0;
      wm_q <= wm_cfg; wr_ack <= 1'b0;
    end else begin
      wr_ack <= wr_ok;
      if (path_reset) begin
        wr_ptr <= '0; rd_ptr <= '0; count <= '0; frame_cnt <= '0;
        wm_q <= wm_cfg;
      end else begin
        if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
        if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
        count <= count + CW'(wr_ok) - CW'(rd_ok);
        frame_cnt <= frame_cnt + CW'(wr_ok && wr_last) - CW'(rd_ok && head_last);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st0 <= '0; st1 <= '0; st_cnt <= 2'd0;
    end else begin
      if (pop_ok && push_ok) begin
        if (st_cnt == 2'd1) st0 <= st_new;
        else begin st0 <= st1; st1 <= st_new; end
      end else if (pop_ok) begin
        st0 <= st1;
        st_cnt <= st_cnt - 2'd1;
      end else if (push_ok) begin
        if (st_cnt == 2'd0) st0 <= st_new;
        else st1 <= st_new;
        st_cnt <= st_cnt + 2'd1;
      end
    end

  a_r4_full_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> !wr_ack);
  a_r4_full_held: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !mac_rd && !path_reset) |=> (count == CW'(DEPTH)));
  a_r8_two_pending_block: assert property (@(posedge clk) disable iff (!rst_n)
    (st_cnt == 2'd2) |-> !start_ok);
  a_r7_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !done_valid && st_cnt != 2'd0) |=> (st_cnt == $past(st_cnt) - 2'd1));
  a_r10_wm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !path_reset |=> $stable(wm_q));
  a_r3_ack_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_ack);
  always_comb a_r6_frames_bound: assert (!rst_n || frame_cnt <= count);
endmodule

// File: tb/test_tx_host_port.sv
module test_tx_host_port;
  localparam int DEPTH = 16, DW = 8, RW = 4;
  logic clk = 0, rst_n = 0, path_reset = 0, wr_en = 0, wr_last = 0, mac_rd = 0;
  logic done_valid = 0, done_uflo = 0, st_rd = 0;
  logic [4:0] wm_cfg = 5'd4;
  logic [DW-1:0] wr_data = 0;
  logic [RW-1:0] done_retry = 0;
  logic wr_ack, data_req, mac_last, mac_avail, start_ok;
  logic [DW-1:0] mac_data;
  logic [4:0] frame_cnt;
  logic [RW+1:0] st_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  tx_host_port #(.DEPTH(DEPTH), .DW(DW), .RW(RW)) i_tx_host_port (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(logic [7:0] d, logic l);
    wr_en = 1; wr_data = d; wr_last = l; step(); wr_en = 0; wr_last = 0;
  endtask

  task automatic push(logic u, logic [3:0] r);
    done_valid = 1; done_uflo = u; done_retry = r; step(); done_valid = 0;
  endtask

  localparam logic [9:0] VEC [5] = '{
    {8'hA1, 1'b0, 1'b0}, {8'hA2, 1'b0, 1'b0}, {8'hA3, 1'b1, 1'b1},
    {8'hB1, 1'b0, 1'b1}, {8'hB2, 1'b1, 1'b0}
  };
  localparam int FR_EXP [5] = '{0, 0, 1, 1, 2};

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 ack", wr_ack, 0); chk("R1 frame_cnt", frame_cnt, 0);
    chk("R1 st_data", st_data, 0); chk("R1 start_ok", start_ok, 0);
    chk("R1 avail", mac_avail, 0);
    rst_n = 1; step();
    chk("R1 ack after", wr_ack, 0); chk("R2 req empty", data_req, 1);

    for (int i = 0; i < 5; i++) begin
      wr(VEC[i][9:2], VEC[i][1]);
      chk("R3 ack pulse", wr_ack, 1);
      chk("R6 frame_cnt", frame_cnt, FR_EXP[i]);
      step();
      chk("R3 ack single", wr_ack, 0);
    end
    chk("R8 start_ok", start_ok, 1);
    chk("R5 avail", mac_avail, 1);

    for (int i = 0; i < 11; i++) begin
      wr(8'hF0 + 8'(i), 1'b0);
      if (i == 6) chk("R2 req at free 4", data_req, 1);
      if (i == 7) chk("R2 req at free 3", data_req, 0);
    end
    wr(8'hEE, 1'b0);
    chk("R4 no ack when full", wr_ack, 0);
    chk("R5 head", mac_data, 8'hA1);
    wr_en = 1; wr_data = 8'hEF; mac_rd = 1; step(); wr_en = 0; mac_rd = 0;
    chk("R4 no ack with pop", wr_ack, 0);

    begin
      logic [7:0] exp_seq [15] = '{8'hA2, 8'hA3, 8'hB1, 8'hB2, 8'hF0, 8'hF1,
        8'hF2, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hF7, 8'hF8, 8'hF9, 8'hFA};
      for (int i = 0; i < 15; i++) begin
        chk("R5 order", mac_data, exp_seq[i]);
        if (i == 1 || i == 3) chk("R5 last mark", mac_last, 1);
        mac_rd = 1; step(); mac_rd = 0;
        if (i == 1) chk("R6 frame dec", frame_cnt, 1);
        if (i == 3) chk("R6 frame zero", frame_cnt, 0);
      end
    end
    chk("R4 full write not stored", mac_avail, 0);

    chk("R7 empty zero", st_data, 0);
    wr(8'h11, 1'b1);
    push(1'b1, 4'd3); push(1'b0, 4'd5);
    chk("R8 blocked two pending", start_ok, 0);
    chk("R7 oldest", st_data, 6'b110011);
    st_rd = 1; done_valid = 1; done_uflo = 1; done_retry = 4'd9; step();
    st_rd = 0; done_valid = 0;
    chk("R9 push+pop head", st_data, 6'b100101);
    chk("R8 still two", start_ok, 0);
    push(1'b0, 4'd1);
    st_rd = 1; step();
    chk("R9 new entry kept", st_data, 6'b111001);
    step(); st_rd = 0;
    chk("R9 dropped push", st_data, 0);
    chk("R8 permit back", start_ok, 1);

    push(1'b0, 4'd2);
    wm_cfg = 5'd16; step();
    chk("R10 wm not loaded", data_req, 1);
    path_reset = 1; step(); path_reset = 0;
    chk("R10 frames cleared", frame_cnt, 0);
    chk("R10 fifo cleared", mac_avail, 0);
    chk("R10 status kept", st_data, 6'b100010);
    chk("R2 req at wm 16", data_req, 1);
    wr(8'h22, 1'b0);
    chk("R10 wm loaded", data_req, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule